// File: doc/BRIEF.md
# Software Interrupt Priority Controller

This block merges a bank of external interrupt-level lines with a 32-bit software interrupt register. From the two it forms a pending vector over levels 1 to 15 and selects the highest one. It then reports that level to a processor core as an external-interrupt trap index, together with a hard-interrupt request. Level 0 means that nothing is pending.

The core changes the software register with three privileged operations: set, clear and replace. The operand of each operation is the XOR of two source values. In user mode the operation is refused and an illegal-instruction flag is raised. Any of three timer-compare events posts bit 0 of the register, which is the timer bit. The scan treats that bit as level 14. A rising external line produces a one-cycle wake pulse for a halted core. The core can also load its own trap index. While that index lies outside the external range, the controller leaves it in place.

Top module: `swirq_prio_top`

## Requirements
- R1: A synchronous reset clears the software register, `trapIdx`, `hardReq`, `newIrq` and `wakeCore`. All five read 0 after reset.
- R2: When `opValid` is high and `supervisor` is high, `opSel` selects the operation: 2'b01 ORs the operand into the register, 2'b10 clears the operand's set bits, 2'b11 replaces the register and 2'b00 does nothing. The operand is the low 32 bits of `opSrcA ^ opSrcB`. The result appears on `swRead` after the next rising edge.
- R3: If `opValid` is high, `opSel` is not 2'b00 and `supervisor` is low, `illegalOp` is high in that same cycle and the register keeps its value. In every other case `illegalOp` is low.
- R4: A pulse on `tickEvt`, `stickEvt` or `htickEvt` sets register bit 0 at the next edge. This happens even when a set, clear or replace runs in the same cycle: the operation is applied and bit 0 still ends up set.
- R5: Level i (1 to 15) is pending when `extLevel[i]` or register bit i is high. Register bit 0 also makes level 14 pending. `extLevel[0]` and register bits 31:16 never make any level pending.
- R6: The highest pending level wins. The index installed is 8'h40 ORed with that level in bits 3:0, which gives 8'h41 to 8'h4F.
- R7: A new index is installed only when the current `trapIdx` is 0 or its bits 7:4 equal 4'h4. Any other index is held, whatever is pending.
- R8: When no level is pending and bits 7:4 of `trapIdx` equal 4'h4, `trapIdx` returns to 0 and `hardReq` drops at the next edge.
- R9: `newIrq` pulses for one cycle, and `hardReq` rises, only when an installed index differs from the previous one. If the installed index is unchanged, `newIrq` stays low.
- R10: When any of `extLevel[15:1]` rises, `wakeCore` is high for exactly one cycle after the edge that samples the rise. A falling line never produces a pulse.
- R11: A change on `extLevel` reaches `trapIdx` at the first rising edge. A register operation reaches `trapIdx` at the second rising edge.
- R12: While `coreIdxLoad` is high, `trapIdx` takes `coreIdx` at the next edge. This load takes precedence over both installing and retiring an index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| extLevel | input | 16 | External level lines; bit i requests level i, bit 0 unused |
| tickEvt | input | 1 | Tick compare event |
| stickEvt | input | 1 | System tick compare event |
| htickEvt | input | 1 | Hyper tick compare event |
| opValid | input | 1 | A software-register operation is presented |
| opSel | input | 2 | Operation: 01 set, 10 clear, 11 replace, 00 none |
| opSrcA | input | 64 | First operand source |
| opSrcB | input | 64 | Second operand source |
| supervisor | input | 1 | Core runs in supervisor mode |
| coreIdxLoad | input | 1 | Core loads its own trap index |
| coreIdx | input | 8 | Index to load |
| illegalOp | output | 1 | Refused operation in user mode |
| swRead | output | 32 | Software register read port |
| trapIdx | output | 8 | Current trap index |
| hardReq | output | 1 | Hard-interrupt request level |
| newIrq | output | 1 | One-cycle pulse when a different index is installed |
| wakeCore | output | 1 | One-cycle halt-release pulse |

## Verification
The priority scan is tried from three directions. The first is register bits alone, set through an XOR operand whose upper halves cancel. The second is external lines alone, raised and lowered in a staggered order, so that a winner that moves up can be told apart from one that falls back. The third is the timer bit alone, which must come out as level 14 and lose to level 15. Bits that count for no level, namely `extLevel[0]` and register bits 31:16, must leave the index at zero. A lower level added beneath the current winner must produce no new pulse. A core-loaded index outside the external range must survive both pending requests and the retire rule, which separates the eligibility test from plain priority.

// File: rtl/swirq_pkg.sv
package swirq_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_WR   = 2'b11
  } swOp_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic opSet;
    logic opClr;
    logic opWr;
    logic timerHit;
    logic idxInstall;
    logic idxRetire;
    logic idxLoad;
  } ctrlStrobe_t;

endpackage

// File: rtl/swirq_scan.sv
module swirq_scan #(
  parameter int LEVELS = 16,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] pendVec,
  output logic [LVL_W-1:0]  winLevel,
  output logic              pendAny
);

  // Ascending loop: a later (higher) hit overrides, so the top level wins.
  always_comb begin
    winLevel = '0;
    for (int i = 1; i < LEVELS; i++) begin
      if (pendVec[i]) winLevel = LVL_W'(i);
    end
  end

  assign pendAny = |pendVec[LEVELS-1:1];

endmodule

// File: rtl/swirq_ctrl.sv
module swirq_ctrl
  import swirq_pkg::*;
#(
  parameter int              LEVELS   = 16,
  parameter int              IDX_W    = 8,
  parameter logic [IDX_W-1:0] EXT_BASE = 8'h40,
  localparam int             LVL_W    = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [1:0]        opSel,
  input  logic              supervisor,
  input  logic              tickEvt,
  input  logic              stickEvt,
  input  logic              htickEvt,
  input  logic [LEVELS-1:0] extLevel,
  input  logic              coreIdxLoad,
  input  logic              pendAny,
  input  logic [IDX_W-1:0]  idxCur,
  output ctrlStrobe_t       strobe,
  output logic              illegalOp,
  output logic              wakeCore
);

  logic opReq, opOk, inRange, eligible;
  logic [LEVELS-1:1] extPrev;

  assign opReq     = opValid && (swOp_e'(opSel) != OP_NONE);
  assign opOk      = opReq && supervisor;
  assign illegalOp = opReq && !supervisor;

  assign inRange  = (idxCur[IDX_W-1:LVL_W] == EXT_BASE[IDX_W-1:LVL_W]);
  assign eligible = (idxCur == '0) || inRange;

  always_comb begin
    strobe            = '0;
    strobe.opSet      = opOk && (swOp_e'(opSel) == OP_SET);
    strobe.opClr      = opOk && (swOp_e'(opSel) == OP_CLR);
    strobe.opWr       = opOk && (swOp_e'(opSel) == OP_WR);
    strobe.timerHit   = tickEvt || stickEvt || htickEvt;
    strobe.idxLoad    = coreIdxLoad;
    strobe.idxInstall = !coreIdxLoad && pendAny && eligible;
    strobe.idxRetire  = !coreIdxLoad && !pendAny && inRange;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      extPrev  <= '0;
      wakeCore <= 1'b0;
    end else begin
      extPrev  <= extLevel[LEVELS-1:1];
      wakeCore <= |(extLevel[LEVELS-1:1] & ~extPrev);
    end
  end

  // R12: a core load suppresses both automatic index updates
  a_r12_load_wins: assert property (@(posedge clk) disable iff (rst)
    coreIdxLoad |-> !(strobe.idxInstall || strobe.idxRetire));

  // R3: a refused operation produces no write strobe
  a_r3_no_write_strobe: assert property (@(posedge clk) disable iff (rst)
    illegalOp |-> !(strobe.opSet || strobe.opClr || strobe.opWr));

endmodule

// File: rtl/swirq_dpath.sv
module swirq_dpath
  import swirq_pkg::*;
#(
  parameter int              LEVELS   = 16,
  parameter int              SW_W     = 32,
  parameter int              IDX_W    = 8,
  parameter logic [IDX_W-1:0] EXT_BASE = 8'h40,
  localparam int             LVL_W    = $clog2(LEVELS),
  localparam int             TIMER_LEVEL = LEVELS - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [SW_W-1:0]   opnd,
  input  logic [LEVELS-1:0] extLevel,
  input  logic [IDX_W-1:0]  coreIdx,
  output logic [SW_W-1:0]   swReg,
  output logic              pendAny,
  output logic [IDX_W-1:0]  trapIdx,
  output logic              hardReq,
  output logic              newIrq
);

  logic [SW_W-1:0]   swNext;
  logic [LEVELS-1:0] pendVec;
  logic [LVL_W-1:0]  winLevel;
  logic [IDX_W-1:0]  newIdx;

  always_comb begin
    swNext = swReg;
    if (strobe.opSet)      swNext = swReg | opnd;
    else if (strobe.opClr) swNext = swReg & ~opnd;
    else if (strobe.opWr)  swNext = opnd;
    if (strobe.timerHit)   swNext[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) swReg <= '0;
    else     swReg <= swNext;
  end

  assign pendVec[0] = 1'b0;
  for (genvar lv = 1; lv < LEVELS; lv++) begin : g_pend
    if (lv == TIMER_LEVEL) begin : g_timer
      assign pendVec[lv] = extLevel[lv] | swReg[lv] | swReg[0];
    end else begin : g_plain
      assign pendVec[lv] = extLevel[lv] | swReg[lv];
    end
  end

  swirq_scan #(.LEVELS(LEVELS)) u_scan (
    .pendVec (pendVec),
    .winLevel(winLevel),
    .pendAny (pendAny)
  );

  assign newIdx = EXT_BASE | {{(IDX_W-LVL_W){1'b0}}, winLevel};

  always_ff @(posedge clk) begin
    if (rst) begin
      trapIdx <= '0;
      hardReq <= 1'b0;
      newIrq  <= 1'b0;
    end else begin
      newIrq <= 1'b0;
      if (strobe.idxLoad) begin
        trapIdx <= coreIdx;
      end else if (strobe.idxInstall) begin
        trapIdx <= newIdx;
        if (newIdx != trapIdx) begin
          newIrq  <= 1'b1;
          hardReq <= 1'b1;
        end
      end else if (strobe.idxRetire) begin
        trapIdx <= '0;
        hardReq <= 1'b0;
      end
    end
  end

  // R4: a timer event leaves the timer bit set
  a_r4_timer_bit: assert property (@(posedge clk) disable iff (rst)
    strobe.timerHit |=> swReg[0]);

  // R9: a fresh index always comes with the request level
  a_r9_pulse_has_req: assert property (@(posedge clk) disable iff (rst)
    newIrq |-> hardReq);

  // R6: an installed index carries a nonzero level
  a_r6_level_nonzero: assert property (@(posedge clk) disable iff (rst)
    strobe.idxInstall |=> (trapIdx[LVL_W-1:0] != '0));

endmodule

// File: rtl/swirq_prio_top.sv
module swirq_prio_top
  import swirq_pkg::*;
#(
  parameter int              LEVELS   = 16,
  parameter int              SW_W     = 32,
  parameter int              OPND_W   = 64,
  parameter int              IDX_W    = 8,
  parameter logic [IDX_W-1:0] EXT_BASE = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:0] extLevel,
  input  logic              tickEvt,
  input  logic              stickEvt,
  input  logic              htickEvt,
  input  logic              opValid,
  input  logic [1:0]        opSel,
  input  logic [OPND_W-1:0] opSrcA,
  input  logic [OPND_W-1:0] opSrcB,
  input  logic              supervisor,
  input  logic              coreIdxLoad,
  input  logic [IDX_W-1:0]  coreIdx,
  output logic              illegalOp,
  output logic [SW_W-1:0]   swRead,
  output logic [IDX_W-1:0]  trapIdx,
  output logic              hardReq,
  output logic              newIrq,
  output logic              wakeCore
);

  ctrlStrobe_t     strobe;
  logic            pendAny;
  logic [SW_W-1:0] opnd;

  assign opnd = opSrcA[SW_W-1:0] ^ opSrcB[SW_W-1:0];

  swirq_ctrl #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .EXT_BASE(EXT_BASE)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opValid    (opValid),
    .opSel      (opSel),
    .supervisor (supervisor),
    .tickEvt    (tickEvt),
    .stickEvt   (stickEvt),
    .htickEvt   (htickEvt),
    .extLevel   (extLevel),
    .coreIdxLoad(coreIdxLoad),
    .pendAny    (pendAny),
    .idxCur     (trapIdx),
    .strobe     (strobe),
    .illegalOp  (illegalOp),
    .wakeCore   (wakeCore)
  );

  swirq_dpath #(
    .LEVELS(LEVELS), .SW_W(SW_W), .IDX_W(IDX_W), .EXT_BASE(EXT_BASE)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .opnd    (opnd),
    .extLevel(extLevel),
    .coreIdx (coreIdx),
    .swReg   (swRead),
    .pendAny (pendAny),
    .trapIdx (trapIdx),
    .hardReq (hardReq),
    .newIrq  (newIrq)
  );

  // R3: a refused operation with no timer event leaves the register as it was
  a_r3_reg_kept: assert property (@(posedge clk) disable iff (rst)
    (illegalOp && !(tickEvt || stickEvt || htickEvt)) |=> $stable(swRead));

  // R10: the wake pulse lasts one cycle while the lines hold still
  a_r10_single_wake: assert property (@(posedge clk) disable iff (rst)
    (wakeCore && $stable(extLevel)) |=> !wakeCore);

endmodule

// File: tb/swirq_prio_top_test.sv
`timescale 1ns/100ps
module swirq_prio_top_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] extLevel;
  logic        tickEvt, stickEvt, htickEvt;
  logic        opValid;
  logic [1:0]  opSel;
  logic [63:0] opSrcA, opSrcB;
  logic        supervisor;
  logic        coreIdxLoad;
  logic [7:0]  coreIdx;
  logic        illegalOp;
  logic [31:0] swRead;
  logic [7:0]  trapIdx;
  logic        hardReq, newIrq, wakeCore;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  swirq_prio_top uut (
    .clk(clk), .rst(rst), .extLevel(extLevel),
    .tickEvt(tickEvt), .stickEvt(stickEvt), .htickEvt(htickEvt),
    .opValid(opValid), .opSel(opSel), .opSrcA(opSrcA), .opSrcB(opSrcB),
    .supervisor(supervisor), .coreIdxLoad(coreIdxLoad), .coreIdx(coreIdx),
    .illegalOp(illegalOp), .swRead(swRead), .trapIdx(trapIdx),
    .hardReq(hardReq), .newIrq(newIrq), .wakeCore(wakeCore)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; extLevel = '0; tickEvt = 0; stickEvt = 0; htickEvt = 0;
    opValid = 0; opSel = 2'b00; opSrcA = '0; opSrcB = '0;
    supervisor = 1'b1; coreIdxLoad = 0; coreIdx = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // Presents one operation for one cycle; returns at the negedge after it.
  task automatic swOp(input logic [1:0] sel, input logic [63:0] a,
                      input logic [63:0] b, input logic sup);
    opValid = 1'b1; opSel = sel; opSrcA = a; opSrcB = b; supervisor = sup;
    #1;
    chk("R3", "illegalOp during op", illegalOp, (!sup && sel != 2'b00));
    @(negedge clk);
    opValid = 1'b0; opSel = 2'b00; supervisor = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    extLevel[3] = 1'b1;
    swOp(2'b01, 64'h20, 64'h0, 1'b1);
    @(negedge clk);
    doReset();
    chk("R1", "swRead", swRead, 0);
    chk("R1", "trapIdx", trapIdx, 0);
    chk("R1", "hardReq", hardReq, 0);
    chk("R1", "newIrq", newIrq, 0);
    chk("R1", "wakeCore", wakeCore, 0);
  endtask

  task automatic testSwSet();
    doReset();
    swOp(2'b01, 64'hFFFF_0000_0000_0020, 64'hFFFF_0000_0000_0000, 1'b1);
    chk("R2", "set via xor operand", swRead, 32'h20);
    chk("R11", "index not yet after one edge", trapIdx, 0);
    @(negedge clk);
    chk("R6", "index level 5", trapIdx, 8'h45);
    chk("R9", "newIrq on install", newIrq, 1);
    chk("R9", "hardReq on install", hardReq, 1);
    @(negedge clk);
    chk("R9", "newIrq one cycle", newIrq, 0);
    chk("R9", "hardReq held", hardReq, 1);
    swOp(2'b01, 64'h8, 64'h0, 1'b1);
    chk("R2", "set merges", swRead, 32'h28);
    @(negedge clk);
    chk("R6", "lower level does not win", trapIdx, 8'h45);
    chk("R9", "no pulse when unchanged", newIrq, 0);
  endtask

  task automatic testExt();
    doReset();
    extLevel[9] = 1'b1;
    @(negedge clk);
    chk("R11", "ext reaches index in one edge", trapIdx, 8'h49);
    chk("R10", "wake on rise", wakeCore, 1);
    chk("R9", "newIrq ext", newIrq, 1);
    @(negedge clk);
    chk("R10", "wake single cycle", wakeCore, 0);
    extLevel[12] = 1'b1;
    @(negedge clk);
    chk("R6", "higher level wins", trapIdx, 8'h4C);
    chk("R10", "wake on second rise", wakeCore, 1);
    extLevel[12] = 1'b0;
    @(negedge clk);
    chk("R6", "falls back to 9", trapIdx, 8'h49);
    chk("R10", "no wake on fall", wakeCore, 0);
    chk("R9", "newIrq on fallback", newIrq, 1);
    extLevel[9] = 1'b0;
    @(negedge clk);
    chk("R8", "index retired", trapIdx, 0);
    chk("R8", "hardReq dropped", hardReq, 0);
    extLevel[0] = 1'b1;
    @(negedge clk);
    chk("R5", "ext bit 0 no level", trapIdx, 0);
    chk("R10", "ext bit 0 no wake", wakeCore, 0);
  endtask

  task automatic testClrWr();
    doReset();
    swOp(2'b11, 64'h8001_0004, 64'h0001_0000, 1'b1);
    chk("R2", "replace", swRead, 32'h8000_0004);
    @(negedge clk);
    chk("R6", "index level 2", trapIdx, 8'h42);
    swOp(2'b11, 64'hFFFF_0000, 64'h0, 1'b1);
    chk("R2", "replace upper", swRead, 32'hFFFF_0000);
    @(negedge clk);
    chk("R5", "upper bits no level", trapIdx, 0);
    chk("R8", "hardReq low", hardReq, 0);
    swOp(2'b10, 64'hFFFF_0000, 64'h0, 1'b1);
    chk("R2", "clear", swRead, 0);
    swOp(2'b01, 64'h30, 64'h0, 1'b1);
    swOp(2'b10, 64'h10, 64'h0, 1'b1);
    chk("R2", "partial clear", swRead, 32'h20);
    swOp(2'b00, 64'hFF, 64'h0, 1'b1);
    chk("R2", "no-op code", swRead, 32'h20);
  endtask

  task automatic testTimer();
    doReset();
    tickEvt = 1'b1;
    @(negedge clk);
    tickEvt = 1'b0;
    chk("R4", "tick sets bit 0", swRead, 1);
    @(negedge clk);
    chk("R5", "timer bit as level 14", trapIdx, 8'h4E);
    extLevel[15] = 1'b1;
    @(negedge clk);
    chk("R6", "level 15 beats timer", trapIdx, 8'h4F);
    extLevel[15] = 1'b0;
    stickEvt = 1'b1;
    swOp(2'b10, 64'h1, 64'h0, 1'b1);
    stickEvt = 1'b0;
    chk("R4", "stick wins over clear", swRead, 1);
    htickEvt = 1'b1;
    swOp(2'b11, 64'h0, 64'h0, 1'b1);
    htickEvt = 1'b0;
    chk("R4", "htick wins over replace", swRead, 1);
    swOp(2'b11, 64'h0, 64'h0, 1'b1);
    chk("R2", "replace zero", swRead, 0);
    tickEvt = 1'b1;
    swOp(2'b01, 64'h4, 64'h0, 1'b1);
    tickEvt = 1'b0;
    chk("R4", "set and tick together", swRead, 32'h5);
  endtask

  task automatic testUser();
    doReset();
    swOp(2'b01, 64'h20, 64'h0, 1'b1);
    swOp(2'b01, 64'hFF, 64'h0, 1'b0);
    chk("R3", "user set ignored", swRead, 32'h20);
    swOp(2'b11, 64'h0, 64'h0, 1'b0);
    chk("R3", "user replace ignored", swRead, 32'h20);
    swOp(2'b10, 64'h20, 64'h0, 1'b0);
    chk("R3", "user clear ignored", swRead, 32'h20);
    swOp(2'b00, 64'h0, 64'h0, 1'b0);
    chk("R3", "user no-op", swRead, 32'h20);
  endtask

  task automatic testCoreLoad();
    doReset();
    coreIdxLoad = 1'b1; coreIdx = 8'h10;
    @(negedge clk);
    coreIdxLoad = 1'b0;
    chk("R12", "core index loaded", trapIdx, 8'h10);
    @(negedge clk);
    chk("R7", "foreign index not retired", trapIdx, 8'h10);
    swOp(2'b01, 64'h8, 64'h0, 1'b1);
    @(negedge clk);
    chk("R7", "foreign index held", trapIdx, 8'h10);
    chk("R7", "no pulse while held", newIrq, 0);
    extLevel[9] = 1'b1; coreIdxLoad = 1'b1; coreIdx = 8'h00;
    @(negedge clk);
    coreIdxLoad = 1'b0;
    chk("R12", "load beats install", trapIdx, 0);
    @(negedge clk);
    chk("R7", "install once index empty", trapIdx, 8'h49);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    testReset();
    testSwSet();
    testExt();
    testClrWr();
    testTimer();
    testUser();
    testCoreLoad();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule